// File: doc/BRIEF.md
# Byte-Addressed Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C protocol, 7-bit addressing) that gives a bus master access to a 256-byte register array. SCL and SDA enter through two-flop synchronizers and are sampled in the system clock domain. The block drives SDA only as an open-drain pull-low enable; the pad and pull-up are outside. The first byte after START is matched against a fixed 6-bit prefix plus one bit taken from a strap input. The next byte of a write loads an internal byte pointer. Every later data byte is stored at the pointer, and the pointer then steps by one.

Reads use a separate transaction with the direction bit set. The target returns bytes from the pointer for as long as the master acknowledges. The pointer is kept across STOP, so a read can carry on from where the last access left off. At reset the array is filled with computed default bytes, which model a power-up configuration image. A cycle-count timeout, which can be enabled or disabled, drops a transaction that has stalled and releases SDA.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, SDA is released, the byte pointer is 0, and register a holds {a[3:0],a[7:4]} XOR 8'h3C.
- R2: The target acknowledges an address byte whose upper seven bits equal {6'b110000, addr_sel}, by pulling SDA low in the ninth clock. Bit 0 of that byte selects the direction: 0 is write and 1 is read.
- R3: A non-matching address byte is not acknowledged. All traffic after it, until the next START, leaves SDA undriven and changes no register.
- R4: In a write, the byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments. The target acknowledges every byte.
- R5: In a read, the target shifts out the byte at the pointer, MSB first, and increments the pointer after each byte. It continues while the master acknowledges.
- R6: After the master NACKs a read byte, the target drives nothing until the next START or STOP.
- R7: The pointer keeps its value across STOP, so a new read starts at the pointer left by the previous access.
- R8: The pointer wraps from 255 to 0 during both burst writes and burst reads.
- R9: A repeated START inside a transaction returns the target to address matching.
- R10: A STOP returns the target to idle with SDA released.
- R11: With timeout_en high, a transaction with no SCL edge for TIMEOUT_CYCLES system clocks is dropped and SDA is released. With timeout_en low, the target keeps driving.
- R12: The target changes its SDA drive only while SCL is low, except when it drops to idle.
- R13: Operation is correct for any SCL rate at which each SCL high and low phase lasts at least 6 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel | input | 1 | Strap that supplies bit 0 of the 7-bit target address |
| timeout_en | input | 1 | Enables the stalled-bus timeout |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A wrong phase state shows up at sda_pull within one byte. It appears as an acknowledge in the wrong clock, as a missing acknowledge, or as read data shifted by a bit, and each of these is visible in the ninth clock after the fault. A wrong pointer or a lost write does not show on the wire until the affected location is read back. For that reason, each write burst is followed by a read of the same range, and a read that continues from the last pointer is used to expose pointer drift. Timeout faults show only as SDA held low (or released early) at a known count of cycles after the last SCL edge.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [5:0] ADDR_HIGH      = 6'b110000,
  parameter int         TIMEOUT_CYCLES = 3_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel,
  input  logic timeout_en,
  output logic sda_pull
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_REG, S_WDATA, S_WACK, S_RDATA, S_MACK, S_IGNORE
  } state_t;

  function automatic logic [7:0] dflt(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end

  wire scl_s     = scl_sync[1];
  wire sda_s     = sda_sync[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  state_t        state;
  logic [3:0]    cnt;
  logic [7:0]    sr;
  logic [7:0]    ptr;
  logic          rw;
  logic          mack_n;
  logic [TW-1:0] to_cnt;
  logic [7:0]    mem [256];

  wire byte_done = scl_fall && (cnt == 4'd8);
  wire to_fire   = timeout_en && (state != S_IDLE) && (to_cnt == TO_LAST);
  wire wr_en     = (state == S_WDATA) && byte_done && !start_det && !stop_det && !to_fire;
  wire [7:0] rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      to_cnt <= '0;
    else if (state == S_IDLE || !timeout_en || scl_rise || scl_fall || start_det || stop_det)
      to_cnt <= '0;
    else if (to_cnt != TO_LAST)
      to_cnt <= to_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= dflt(8'(i));
    end else if (wr_en) begin
      mem[ptr] <= sr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      sr       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      mack_n   <= 1'b1;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= S_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (to_fire) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_REG, S_WDATA: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == S_ADDR) begin
              if (sr[7:1] == {ADDR_HIGH, addr_sel}) begin
                rw       <= sr[0];
                sda_pull <= 1'b1;
                state    <= S_AACK;
              end else begin
                state    <= S_IGNORE;
              end
            end else begin
              if (state == S_REG) ptr <= sr;
              else                ptr <= ptr + 8'd1;
              sda_pull <= 1'b1;
              state    <= S_WACK;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sr       <= rd_byte;
              sda_pull <= ~rd_byte[7];
              state    <= S_RDATA;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_REG;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            cnt      <= '0;
            sda_pull <= 1'b0;
            state    <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull <= 1'b0;
              ptr      <= ptr + 8'd1;
              state    <= S_MACK;
            end else begin
              sr       <= {sr[6:0], 1'b0};
              sda_pull <= ~sr[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_n <= sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (!mack_n) begin
              sr       <= rd_byte;
              sda_pull <= ~rd_byte[7];
              state    <= S_RDATA;
            end else begin
              state    <= S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_pull); // R10
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE && !sda_pull)); // R10
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGNORE) |-> !sda_pull); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 8'd1)); // R8
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> (!scl_s || state == S_IDLE)); // R12
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (to_cnt == TO_LAST && timeout_en && state != S_IDLE) |=> (state == S_IDLE || state == S_ADDR)); // R11

endmodule

// File: tb/i2c_regfile_target_test.sv
module i2c_regfile_target_test;

  localparam int TO = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic timeout_en = 1'b1;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_regfile_target #(.ADDR_HIGH(6'b110000), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .timeout_en(timeout_en), .sda_pull(sda_pull)
  );

  int checks = 0;
  int fails = 0;
  int q = 8;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 8'd0;
  logic       done = 1'b0;

  function automatic logic [7:0] ref_default(input int a);
    logic [7:0] b = 8'(a);
    return {b[3:0], b[7:4]} ^ 8'h3C;
  endfunction

  function automatic logic [6:0] dev_addr();
    return {6'b110000, addr_sel};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(q);
    scl_m = 1'b1; tick(q);
    sda_m = 1'b0; tick(q);
    scl_m = 1'b0; tick(q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(q);
    scl_m = 1'b1; tick(q);
    sda_m = 1'b1; tick(q);
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; tick(q);
    scl_m = 1'b1; tick(2 * q);
    scl_m = 1'b0; tick(q);
  endtask

  task automatic read_bit(output logic b, output logic stable);
    logic s1;
    sda_m = 1'b1; tick(q);
    scl_m = 1'b1; tick(q);
    s1 = sda_line; tick(q - 1);
    stable = (s1 == sda_line); tick(1);
    scl_m = 1'b0; tick(q);
    b = s1;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a, st;
    for (int i = 7; i >= 0; i--) write_bit(v[i]);
    read_bit(a, st);
    acked = !a;
  endtask

  task automatic recv_byte(input logic do_ack, output logic [7:0] v);
    logic b, st;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b, st);
      v[i] = b;
      chk(st, "R12 data stable while SCL high", 0, 1);
    end
    write_bit(!do_ack);
  endtask

  task automatic set_ptr(input logic [7:0] p, input bit do_stop);
    logic ak;
    bus_start();
    send_byte({dev_addr(), 1'b0}, ak);
    chk(ak, "R2 address ack", ak, 1);
    send_byte(p, ak);
    chk(ak, "R4 pointer byte ack", ak, 1);
    exp_ptr = p;
    if (do_stop) bus_stop();
  endtask

  task automatic write_burst(input logic [7:0] p, input int n, input string tag);
    logic ak;
    logic [7:0] d;
    set_ptr(p, 1'b0);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ak);
      chk(ak, tag, ak, 1);
      exp_mem[exp_ptr] = d;
      exp_ptr = exp_ptr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic read_burst(input int n, input string tag);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte({dev_addr(), 1'b1}, ak);
    chk(ak, "R2 read address ack", ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(d == exp_mem[exp_ptr], tag, d, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    bus_stop();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic ak;
    logic b, st;
    logic [7:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) exp_mem[i] = ref_default(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_pull == 1'b0, "R1 SDA released after reset", sda_pull, 0);

    // R1: pointer starts at 0, defaults visible
    read_burst(4, "R1 default contents from pointer 0");

    // R4 R5 directed burst
    write_burst(8'h10, 5, "R4 data byte ack");
    set_ptr(8'h10, 1'b1);
    read_burst(5, "R5 burst readback");

    // R7 pointer persists across STOP
    write_burst(8'h30, 3, "R4 data byte ack");
    read_burst(3, "R7 read continues from kept pointer");

    // R13 random traffic at varied SCL rates
    for (int it = 0; it < 10; it++) begin
      logic [7:0] p;
      int n;
      q = 6 + int'($urandom % 11);
      p = 8'($urandom);
      n = 1 + int'($urandom % 5);
      write_burst(p, n, "R13 random write ack");
      set_ptr(p, 1'b1);
      read_burst(n, "R13 random readback");
    end
    q = 8;

    // R8 wrap on write and read
    write_burst(8'hFE, 4, "R8 wrap write ack");
    set_ptr(8'hFE, 1'b1);
    read_burst(4, "R8 wrap readback");

    // R9 repeated START between pointer set and read
    set_ptr(8'h11, 1'b0);
    read_burst(2, "R9 read after repeated start");

    // R6 NACK then silence
    set_ptr(8'h40, 1'b1);
    read_burst(1, "R6 single byte before nack");
    bus_start();
    send_byte({dev_addr(), 1'b1}, ak);
    recv_byte(1'b0, d);
    chk(d == exp_mem[exp_ptr], "R6 byte before nack", d, exp_mem[exp_ptr]);
    exp_ptr = exp_ptr + 8'd1;
    for (int i = 0; i < 8; i++) begin
      read_bit(b, st);
      chk(b == 1'b1, "R6 no drive after nack", b, 1);
    end
    bus_stop();
    read_burst(1, "R7 pointer after nack");

    // R3 mismatched address
    bus_start();
    send_byte({dev_addr() ^ 7'h02, 1'b0}, ak);
    chk(!ak, "R3 foreign address not acked", ak, 0);
    send_byte(8'h20, ak);
    chk(!ak, "R3 pointer byte ignored", ak, 0);
    send_byte(8'hA5, ak);
    chk(!ak, "R3 data byte ignored", ak, 0);
    bus_stop();
    set_ptr(8'h20, 1'b1);
    read_burst(1, "R3 register unchanged");

    // R2 strap selects address LSB
    addr_sel = 1'b1;
    tick(4);
    write_burst(8'h50, 2, "R2 strap-high write ack");
    set_ptr(8'h50, 1'b1);
    read_burst(2, "R2 strap-high readback");
    bus_start();
    send_byte({7'h60, 1'b0}, ak);
    chk(!ak, "R2 strap-low address refused", ak, 0);
    bus_stop();
    addr_sel = 1'b0;
    tick(4);

    // R11 timeout enabled
    timeout_en = 1'b1;
    bus_start();
    for (int i = 7; i >= 0; i--) write_bit(i == 0 ? 1'b0 : dev_addr()[i-1]);
    tick(10);
    chk(sda_pull == 1'b1, "R2 ack held while SCL stalls", sda_pull, 1);
    tick(540);
    chk(sda_pull == 1'b1, "R11 still driving before limit", sda_pull, 1);
    tick(100);
    chk(sda_pull == 1'b0, "R11 released after timeout", sda_pull, 0);
    bus_stop();

    // R11 timeout disabled, R10 stop release
    timeout_en = 1'b0;
    bus_start();
    for (int i = 7; i >= 0; i--) write_bit(i == 0 ? 1'b0 : dev_addr()[i-1]);
    tick(1300);
    chk(sda_pull == 1'b1, "R11 held with timeout disabled", sda_pull, 1);
    scl_m = 1'b1; tick(q);
    scl_m = 1'b0; tick(q);
    chk(sda_pull == 1'b0, "R2 ack released after ninth clock", sda_pull, 0);
    bus_stop();
    tick(5);
    chk(sda_pull == 1'b0, "R10 idle after stop", sda_pull, 0);
    timeout_en = 1'b1;
    read_burst(2, "R7 pointer survives timeout-free abort");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule